// File: doc/BRIEF.md
# Serial Interrupt Bus Host

This block is the host end of a shared, open-drain, single-wire interrupt bus that runs on the PCI clock. Each bus cycle begins with a start frame. A train of three-clock data frames follows. In one slot of each frame a peripheral may pull the line low to report that its interrupt is active. The host samples every slot and rebuilds fifteen interrupt levels and a system-management flag. It publishes all of them together when the cycle ends.

A cycle closes with a stop frame that only the host drives. The length of the stop pulse sets the mode of the next cycle. With three low clocks the bus runs in continuous mode, and the host starts the next cycle by itself as early as the rules allow. With two low clocks the bus runs in quiet mode. The host then waits until a peripheral pulls the idle line low for one clock, and extends that pulse into a full start frame. The enable input stops the host from opening new cycles. A cycle that is already running always finishes.

Top module: `sirq_host`

## Requirements
- R1: While reset is held and just after it, the host does not drive the line, and every bit of `irq_lvl` and `smi_flag` is 0.
- R2: In continuous mode the host opens a cycle by driving the line low for 4 clocks. It then drives the line high for 1 clock and releases it.
- R3: Frame period N is sampled 3N-1 clocks after the clock in which the host drives high at the end of the start frame. A low sample means asserted. Period 2 sets `irq_lvl[1]`, and periods 4 to 16 set `irq_lvl[3]` to `irq_lvl[15]` in order.
- R4: Period 3 is the shared slot and, by default, reports to `smi_flag`. `irq_lvl[2]` then stays 0.
- R5: A low line in period 1 or period 17 changes no output.
- R6: The outputs take the new samples all together in the clock where the stop frame begins. They keep their values at all other times, including through the start frame of the next cycle.
- R7: After the 17th frame the host drives a stop pulse. It lasts 2 low clocks when `stop_quiet` is 1 as the stop begins, and 3 low clocks when it is 0.
- R8: After the stop pulse the host drives high for 1 clock and then releases the line. In continuous mode the next start frame begins exactly 2 clocks after the stop pulse ends, and never earlier in either mode.
- R9: In quiet mode the host never begins a cycle on its own. When it sees the idle line low for one clock, it drives it low for 3 more clocks, then high for 1.
- R10: While `enable` is 0 and the host is idle, it does not drive the line, even when a peripheral pulls it low.
- R11: A cycle, from the first low clock of the start frame to the end of the stop pulse, takes no more than 96 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_in | input | 1 | Level of the shared line |
| stop_quiet | input | 1 | Mode for the next cycle: 1 gives a 2-clock stop (quiet), 0 gives a 3-clock stop (continuous) |
| enable | input | 1 | Allows new cycles to start |
| line_oe | output | 1 | Host drives the line when 1 |
| line_out | output | 1 | Level the host drives while `line_oe` is 1 |
| irq_lvl | output | 15 | Interrupt levels 1 to 15, 1 = asserted; bit index equals the interrupt number |
| smi_flag | output | 1 | System-management request from period 3 |

## Verification
The host decides on a line sample at the clock edge that ends the sample slot. For that reason the bench sets the peripheral's drive at the falling edge that opens the slot's clock, and holds it for exactly that clock. New levels reach the outputs one edge after period 17's turnaround clock, which is the first clock of the stop pulse. The scoreboard compares them at the falling edge that ends the stop pulse, and checks the old values at the end of the next start frame. Mode and gap timing are measured as runs of host-driven clocks sampled at falling edges: 4 or 3 low clocks for a start, 2 or 3 for a stop, and 2 clocks from the end of the stop pulse to the next start in continuous mode.

// File: rtl/sirq_host.sv
module sirq_host #(
  parameter int NUM_FRAMES = 17,
  parameter int START_LOW  = 4,
  parameter bit SMI_ON_P3  = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_in,
  input  logic        stop_quiet,
  input  logic        enable,
  output logic        line_oe,
  output logic        line_out,
  output logic [15:1] irq_lvl,
  output logic        smi_flag
);

  localparam int PW   = $clog2(NUM_FRAMES + 2);
  localparam int CMAX = (START_LOW > 3) ? START_LOW : 3;
  localparam int CW   = $clog2(CMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_FRAMES, S_STOP, S_STOPHI, S_GAP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [1:0]    ph;
  logic [PW-1:0] per;
  logic [16:2]   shd;
  logic          quiet_r, stop_q;
  logic [15:1]   nxt_vec;
  logic          nxt_smi;

  wire frames_done = (st == S_FRAMES) && (per == PW'(NUM_FRAMES + 1)) && (ph == 2'd1);
  wire drive_low   = (st == S_START) || (st == S_STOP);
  wire drive_high  = (st == S_STOPHI) || ((st == S_FRAMES) && (per == PW'(1)) && (ph == 2'd0));
  wire stop_last   = cnt == (stop_q ? CW'(1) : CW'(2));
  wire host_go     = enable && !quiet_r;
  wire peer_go     = enable && quiet_r && !line_in;

  assign line_oe  = drive_low || drive_high;
  assign line_out = drive_high;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      ph      <= '0;
      per     <= '0;
      quiet_r <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (host_go) begin
            st  <= S_START;
            cnt <= '0;
          end else if (peer_go) begin
            st  <= S_START;
            cnt <= CW'(1);
          end
        end
        S_START: begin
          if (cnt == CW'(START_LOW - 1)) begin
            st  <= S_FRAMES;
            ph  <= '0;
            per <= PW'(1);
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_FRAMES: begin
          ph <= (ph == 2'd2) ? 2'd0 : ph + 2'd1;
          if (ph == 2'd2) per <= per + 1'b1;
          if (frames_done) begin
            st     <= S_STOP;
            cnt    <= '0;
            stop_q <= stop_quiet;
          end
        end
        S_STOP: begin
          if (stop_last) begin
            st      <= S_STOPHI;
            quiet_r <= stop_q;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_STOPHI: st <= S_GAP;
        S_GAP: begin
          st  <= host_go ? S_START : S_IDLE;
          cnt <= '0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd <= '0;
    end else if (st == S_FRAMES && ph == 2'd2) begin
      for (int p = 2; p <= 16; p++)
        if (per == PW'(p)) shd[p] <= ~line_in;
    end
  end

  generate
    if (SMI_ON_P3) begin : g_p3_smi
      assign nxt_vec = {shd[16:4], 1'b0, shd[2]};
      assign nxt_smi = shd[3];
    end else begin : g_p3_irq
      assign nxt_vec = shd[16:2];
      assign nxt_smi = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_lvl  <= '0;
      smi_flag <= 1'b0;
    end else if (frames_done) begin
      irq_lvl  <= nxt_vec;
      smi_flag <= nxt_smi;
    end
  end

  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(st == S_STOP && $past(st) == S_FRAMES) |-> ($stable(irq_lvl) && $stable(smi_flag))); // R6

  AST_STOP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STOPHI) |-> ($past(line_oe && !line_out, 1) && $past(line_oe && !line_out, 2) &&
                          ($past(line_oe && !line_out, 3) != $past(stop_q)))); // R7

  AST_START_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == S_FRAMES) |-> (line_oe && line_out && $past(line_oe && !line_out, 1) &&
                               $past(line_oe && !line_out, 2) && $past(line_oe && !line_out, 3))); // R2

  AST_CONT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GAP && enable && !quiet_r) |=> (line_oe && !line_out)); // R8

  AST_QUIET_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && quiet_r && line_in) |=> !line_oe); // R9

  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !enable) |=> !line_oe); // R10

endmodule

// File: tb/test_sirq_host.sv
`timescale 1ns/1ps
module test_sirq_host;
  logic        clk = 1'b0;
  logic        rst_n, stop_quiet, enable, periph_low;
  logic        line_oe, line_out, smi_flag;
  logic [15:1] irq_lvl;
  wire         host_low = line_oe && !line_out;
  wire         line_in  = !(host_low || periph_low);

  typedef struct packed { logic [15:1] vec; logic smi; logic quiet; } exp_t;
  exp_t q[$];

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sirq_host i_sirq_host (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .stop_quiet(stop_quiet),
    .enable(enable), .line_oe(line_oe), .line_out(line_out),
    .irq_lvl(irq_lvl), .smi_flag(smi_flag)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic drive_cycle(input logic [17:1] lp, input logic quiet);
    exp_t e;
    for (int i = 1; i <= 15; i++) e.vec[i] = (i == 2) ? 1'b0 : lp[i+1];
    e.smi   = lp[3];
    e.quiet = quiet;
    q.push_back(e);
    stop_quiet = quiet;
    while (!host_low) @(negedge clk);
    while (host_low) @(negedge clk);
    for (int fc = 0; fc <= 51; fc++) begin
      periph_low = (fc >= 2 && fc % 3 == 2) ? lp[(fc + 1) / 3] : 1'b0;
      @(negedge clk);
    end
    while (!host_low) @(negedge clk);
    while (host_low) @(negedge clk);
  endtask

  task automatic periph_start();
    repeat (3) @(negedge clk);
    periph_low = 1'b1;
    @(negedge clk);
    periph_low = 1'b0;
  endtask

  int cyc = 0, run = 0, gap = 0, start_t = 0;
  bit prev_low = 1'b0, in_stop = 1'b0, last_quiet = 1'b0, have_prev = 1'b0;
  logic [15:1] last_vec = '0;
  logic last_smi = 1'b0;

  initial begin
    exp_t e;
    wait (rst_n === 1'b1);
    forever begin
      @(negedge clk);
      cyc++;
      if (host_low) begin
        if (!prev_low && !in_stop) begin
          start_t = cyc;
          if (have_prev)
            chk(last_quiet ? (gap >= 2) : (gap == 2), "R8 gap before start", gap, 2);
        end
        run++;
      end else if (prev_low) begin
        chk(line_oe && line_out, in_stop ? "R8 high after stop" : "R2 high after start",
            {line_oe, line_out}, 2'b11);
        if (!in_stop) begin
          chk(run == (last_quiet ? 3 : 4), last_quiet ? "R9 stretched start" : "R2 start length",
              run, last_quiet ? 3 : 4);
          chk(irq_lvl == last_vec && smi_flag == last_smi, "R6 outputs held", {irq_lvl, smi_flag},
              {last_vec, last_smi});
          in_stop = 1'b1;
        end else begin
          if (q.size() == 0) begin
            chk(1'b0, "R7 unexpected stop", 0, 1);
          end else begin
            e = q.pop_front();
            chk(run == (e.quiet ? 2 : 3), "R7 stop length", run, e.quiet ? 2 : 3);
            chk(irq_lvl == e.vec, "R3 R5 irq levels", irq_lvl, e.vec);
            chk(smi_flag == e.smi && irq_lvl[2] == 1'b0, "R4 shared slot", {smi_flag, irq_lvl[2]},
                {e.smi, 1'b0});
            chk((cyc - start_t) <= 96, "R11 cycle length", cyc - start_t, 96);
            last_vec   = e.vec;
            last_smi   = e.smi;
            last_quiet = e.quiet;
          end
          in_stop   = 1'b0;
          have_prev = 1'b1;
          gap       = 1;
        end
        run = 0;
      end else if (!in_stop) begin
        gap++;
      end
      prev_low = host_low;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog all requirements act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [17:1] p;
    int n;
    rst_n = 1'b0; enable = 1'b0; stop_quiet = 1'b0; periph_low = 1'b0;
    repeat (5) @(negedge clk);
    chk(!line_oe && irq_lvl == '0 && !smi_flag, "R1 reset state", {line_oe, irq_lvl, smi_flag}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!line_oe && irq_lvl == '0 && !smi_flag, "R1 after reset", {line_oe, irq_lvl, smi_flag}, 0);

    n = 0;
    for (int k = 0; k < 10; k++) begin
      periph_low = (k == 4);
      @(negedge clk);
      if (line_oe) n++;
    end
    periph_low = 1'b0;
    chk(n == 0, "R10 disabled after reset", n, 0);

    enable = 1'b1;
    p = '0; p[2] = 1; p[5] = 1; p[9] = 1;
    drive_cycle(p, 1'b0);
    p = '1;
    drive_cycle(p, 1'b0);
    p = '0; p[3] = 1; p[14] = 1;
    drive_cycle(p, 1'b1);

    n = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (line_oe) n++;
    end
    chk(n == 0, "R9 no self start in quiet mode", n, 0);

    periph_start();
    p = '0; p[1] = 1; p[17] = 1;
    drive_cycle(p, 1'b0);
    p = '0; p[4] = 1; p[10] = 1; p[16] = 1;
    drive_cycle(p, 1'b1);

    enable = 1'b0;
    n = 0;
    for (int k = 0; k < 8; k++) begin
      periph_low = (k == 3 || k == 6);
      @(negedge clk);
      if (line_oe) n++;
    end
    periph_low = 1'b0;
    chk(n == 0, "R10 peripheral ignored when disabled", n, 0);
    chk(irq_lvl == last_vec && smi_flag == last_smi, "R10 outputs kept", {irq_lvl, smi_flag},
        {last_vec, last_smi});

    enable = 1'b1;
    periph_start();
    p = '1; p[3] = 0;
    drive_cycle(p, 1'b0);
    enable = 1'b0;

    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R7 all stops seen", q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule